// File: doc/BRIEF.md
# Out-of-Order Message Reassembly Unit

This block sits on the receive path behind the packet parser and rebuilds application messages from data packets that may arrive in any order. For every arriving data packet the parser issues a lookup carrying the sender address, the sender's message number and the message length in packets. The block answers one cycle later. The answer says whether the message is new, whether it has a buffer, and which local message identifier it uses. On the first packet of a new message a buffer for the whole message is reserved at once. If no buffer is free, or the length is not legal, the answer reports a drop and the parser discards the packet.

Packet payloads are then written with the local identifier and their position inside the message. A per-slot bitmap records which positions have arrived. When the last missing position lands, the block emits a one-cycle completion descriptor. The consumer reads the words through a combinational read port and then acknowledges the identifier, and the slot returns to the pool.

Each slot runs a three-state machine. SLOT_FREE moves to SLOT_FILL through ALLOC, when a lookup misses and this is the lowest-numbered free slot. SLOT_FILL moves to SLOT_DONE through COMPLETE, when an accepted packet fills the last missing position. SLOT_DONE moves to SLOT_FREE through RELEASE, on an acknowledge for that identifier.

Top module: `msg_reassembler`

## Requirements
- R1: After reset every slot is in SLOT_FREE, `rsp_valid` is 0 and `desc_valid` is 0.
- R2: A lookup whose key (source, source message number, length) matches no slot in use, with a length from 1 to MAX_PKTS and a free slot, allocates the lowest-numbered free slot and answers `rsp_new`=1, `rsp_ok`=1 with that slot as `rsp_id`.
- R3: A lookup whose key matches a slot in SLOT_FILL or SLOT_DONE answers `rsp_new`=0, `rsp_ok`=1 and that slot's identifier, and allocates nothing.
- R4: A lookup with length 0, a length above MAX_PKTS, or a new key while no slot is free answers `rsp_ok`=0 (packet dropped) and changes no slot.
- R5: A packet accepted for identifier `pkt_id` at position `pkt_idx` is stored at that position and reads back on `rd_data` when `rd_id`/`rd_idx` select it.
- R6: A packet for a position already received, for a position at or beyond the message length, or for a slot not in SLOT_FILL is ignored: it neither changes stored data nor counts toward completion.
- R7: One cycle after the packet that fills the last missing position, `desc_valid` is 1 for exactly one cycle with that `desc_id` and the message length on `desc_len`, whatever the arrival order.
- R8: An acknowledge for a slot in SLOT_DONE returns it to SLOT_FREE. An acknowledge for a slot in SLOT_FILL is ignored.
- R9: When an acknowledge and a lookup that needs a new slot arrive in the same cycle, the lookup sees the slot state from before the release. The released slot can be allocated from the next cycle on.
- R10: `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_src | input | SRC_W | Sender address of the packet |
| req_smid | input | SMID_W | Sender's message number |
| req_len | input | LEN_W | Message length in packets |
| rsp_valid | output | 1 | Lookup answer strobe |
| rsp_new | output | 1 | Key matched no slot in use |
| rsp_ok | output | 1 | A buffer holds the message (0 means drop) |
| rsp_id | output | ID_W | Local message identifier |
| pkt_valid | input | 1 | Packet word strobe |
| pkt_id | input | ID_W | Local message identifier of the packet |
| pkt_idx | input | IDX_W | Position of the packet in its message |
| pkt_data | input | DATA_W | Packet payload word |
| desc_valid | output | 1 | Completed-message descriptor strobe |
| desc_id | output | ID_W | Identifier of the completed message |
| desc_len | output | LEN_W | Length of the completed message |
| rd_id | input | ID_W | Read port message select |
| rd_idx | input | IDX_W | Read port position select |
| rd_data | output | DATA_W | Stored word at the selected position |
| ack_valid | input | 1 | Consumer release strobe |
| ack_id | input | ID_W | Identifier being released |

## Verification
The reassembly path is tried with every message length from 1 to 4 and every arrival order of that length's packets. A duplicate is injected after the first packet, so an early descriptor, a lost position or a rewrite of a stored word each shows up on its own. Separate patterns fill every slot to provoke drops and send illegal lengths. They also acknowledge a slot that is still filling, send positions beyond the length and packets to free slots, and collide a release with an allocation. These tell apart a released slot used too early, a release that takes effect too late, and a stale bitmap.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/reasm_slot.sv
module reasm_slot
    import reasm_pkg::*;
#(
    parameter int SRC_W    = 8,
    parameter int SMID_W   = 8,
    parameter int MAX_PKTS = 4,
    localparam int LEN_W   = $clog2(MAX_PKTS + 1),
    localparam int IDX_W   = $clog2(MAX_PKTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  key_src,
    input  logic [SMID_W-1:0] key_smid,
    input  logic [LEN_W-1:0]  key_len,
    input  logic              alloc,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              ack,
    output logic              in_use,
    output logic              match,
    output logic              accept,
    output logic              complete,
    output logic [LEN_W-1:0]  len_q
);
    slot_state_e          state, state_nx;
    logic [MAX_PKTS-1:0]  seen, seen_nx, full_mask;
    logic [SRC_W-1:0]     src_q;
    logic [SMID_W-1:0]    smid_q;
    logic                 in_range;

    assign full_mask = (MAX_PKTS'(1) << len_q) - MAX_PKTS'(1);
    assign in_range  = LEN_W'(wr_idx) < len_q;
    assign in_use    = (state != SLOT_FREE);
    assign match     = in_use && (src_q == key_src) && (smid_q == key_smid)
                       && (len_q == key_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SLOT_FREE;
            seen   <= '0;
            src_q  <= '0;
            smid_q <= '0;
            len_q  <= '0;
        end else begin
            state <= state_nx;
            seen  <= seen_nx;
            if (alloc) begin
                src_q  <= key_src;
                smid_q <= key_smid;
                len_q  <= key_len;
            end
        end
    end

    always_comb begin
        state_nx = state;
        seen_nx  = seen;
        accept   = 1'b0;
        complete = 1'b0;
        unique case (state)
            SLOT_FREE: begin
                if (alloc) begin
                    state_nx = SLOT_FILL;
                    seen_nx  = '0;
                end
            end
            SLOT_FILL: begin
                if (wr && in_range && !seen[wr_idx]) begin
                    accept  = 1'b1;
                    seen_nx = seen | (MAX_PKTS'(1) << wr_idx);
                    if (seen_nx == full_mask) begin
                        complete = 1'b1;
                        state_nx = SLOT_DONE;
                    end
                end
            end
            SLOT_DONE: begin
                if (ack) state_nx = SLOT_FREE;
            end
            default: state_nx = SLOT_FREE;
        endcase
    end
endmodule

// File: rtl/reasm_store.sv
module reasm_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/msg_reassembler.sv
module msg_reassembler #(
    parameter int NUM_SLOTS = 4,
    parameter int MAX_PKTS  = 4,
    parameter int SRC_W     = 8,
    parameter int SMID_W    = 8,
    parameter int DATA_W    = 16,
    localparam int ID_W     = $clog2(NUM_SLOTS),
    localparam int LEN_W    = $clog2(MAX_PKTS + 1),
    localparam int IDX_W    = $clog2(MAX_PKTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [SMID_W-1:0] req_smid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic              rsp_new,
    output logic              rsp_ok,
    output logic [ID_W-1:0]   rsp_id,
    input  logic              pkt_valid,
    input  logic [ID_W-1:0]   pkt_id,
    input  logic [IDX_W-1:0]  pkt_idx,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              desc_valid,
    output logic [ID_W-1:0]   desc_id,
    output logic [LEN_W-1:0]  desc_len,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_valid,
    input  logic [ID_W-1:0]   ack_id
);
    localparam int DEPTH  = NUM_SLOTS * MAX_PKTS;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [NUM_SLOTS-1:0] in_use, match, accept, complete, alloc_vec;
    logic [LEN_W-1:0]     slot_len [NUM_SLOTS];
    logic                 len_ok, hit, any_free, grant;
    logic [ID_W-1:0]      hit_id, free_id;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        reasm_slot #(.SRC_W(SRC_W), .SMID_W(SMID_W), .MAX_PKTS(MAX_PKTS)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_src  (req_src),
            .key_smid (req_smid),
            .key_len  (req_len),
            .alloc    (alloc_vec[i]),
            .wr       (pkt_valid && (pkt_id == ID_W'(i))),
            .wr_idx   (pkt_idx),
            .ack      (ack_valid && (ack_id == ID_W'(i))),
            .in_use   (in_use[i]),
            .match    (match[i]),
            .accept   (accept[i]),
            .complete (complete[i]),
            .len_q    (slot_len[i])
        );
        assign alloc_vec[i] = grant && (free_id == ID_W'(i));
    end

    // Lookup: match against slots in use, else pick the lowest free slot.
    always_comb begin
        len_ok   = (req_len != '0) && (int'(req_len) <= MAX_PKTS);
        hit      = |match;
        any_free = ~&in_use;
        hit_id   = '0;
        free_id  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i])   hit_id  = ID_W'(i);
            if (!in_use[i]) free_id = ID_W'(i);
        end
        grant = req_valid && len_ok && !hit && any_free;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_new    <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_id     <= '0;
            desc_valid <= 1'b0;
            desc_id    <= '0;
            desc_len   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_new    <= !hit;
            rsp_ok     <= req_valid && len_ok && (hit || any_free);
            rsp_id     <= hit ? hit_id : (grant ? free_id : '0);
            desc_valid <= |complete;
            desc_id    <= pkt_id;
            desc_len   <= slot_len[pkt_id];
        end
    end

    reasm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (|accept),
        .waddr (ADDR_W'(ADDR_W'(pkt_id) * ADDR_W'(MAX_PKTS) + ADDR_W'(pkt_idx))),
        .wdata (pkt_data),
        .raddr (ADDR_W'(ADDR_W'(rd_id) * ADDR_W'(MAX_PKTS) + ADDR_W'(rd_idx))),
        .rdata (rd_data)
    );
endmodule

// File: rtl/reasm_checker.sv
module reasm_checker #(
    parameter int MAX_PKTS = 4,
    parameter int LEN_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             rsp_valid,
    input logic             rsp_new,
    input logic             rsp_ok,
    input logic             pkt_valid,
    input logic             desc_valid,
    input logic [LEN_W-1:0] desc_len
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_BAD_LEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ((req_len == '0) || (int'(req_len) > MAX_PKTS)) |=> !rsp_ok); // R4
    AST_HIT_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_new |-> rsp_ok); // R3
    AST_DESC_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> $past(pkt_valid)); // R7
    AST_DESC_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_len != '0) && (int'(desc_len) <= MAX_PKTS)); // R7
endmodule

bind msg_reassembler reasm_checker #(.MAX_PKTS(MAX_PKTS), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .rsp_valid  (rsp_valid),
    .rsp_new    (rsp_new),
    .rsp_ok     (rsp_ok),
    .pkt_valid  (pkt_valid),
    .desc_valid (desc_valid),
    .desc_len   (desc_len)
);

// File: tb/tb_msg_reassembler.sv
module tb_msg_reassembler;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0; logic [7:0] req_src = 0, req_smid = 0; logic [2:0] req_len = 0;
    logic rsp_valid, rsp_new, rsp_ok; logic [1:0] rsp_id;
    logic pkt_valid = 0; logic [1:0] pkt_id = 0, pkt_idx = 0; logic [15:0] pkt_data = 0;
    logic desc_valid; logic [1:0] desc_id; logic [2:0] desc_len;
    logic [1:0] rd_id = 0, rd_idx = 0; logic [15:0] rd_data;
    logic ack_valid = 0; logic [1:0] ack_id = 0;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    msg_reassembler dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_req(input int src, input int smid, input int len,
                          output int nw, output int ok, output int id);
        req_valid = 1; req_src = 8'(src); req_smid = 8'(smid); req_len = 3'(len);
        step();
        chk("R10 rsp_valid", int'(rsp_valid), 1);
        nw = int'(rsp_new); ok = int'(rsp_ok); id = int'(rsp_id);
        req_valid = 0;
    endtask

    task automatic do_pkt(input int id, input int idx, input int data,
                          output int dv, output int did, output int dlen);
        pkt_valid = 1; pkt_id = 2'(id); pkt_idx = 2'(idx); pkt_data = 16'(data);
        step();
        dv = int'(desc_valid); did = int'(desc_id); dlen = int'(desc_len);
        pkt_valid = 0;
    endtask

    task automatic do_ack(input int id);
        ack_valid = 1; ack_id = 2'(id);
        step();
        ack_valid = 0;
    endtask

    function automatic int fact(input int n);
        int r = 1;
        for (int i = 2; i <= n; i++) r *= i;
        return r;
    endfunction

    function automatic int word(input int l, input int p, input int idx);
        return ((l << 12) ^ (p << 4) ^ idx ^ 16'h5A00) & 16'hFFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nw, ok, id, dv, did, dlen, k, cnt, sel, f;
        int avail[4];
        int ord[4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1 desc_valid in reset", int'(desc_valid), 0);
        rst_n = 1;
        step();
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1 desc_valid after reset", int'(desc_valid), 0);

        // Every length, every arrival order, duplicate after the first packet.
        for (int l = 1; l <= 4; l++) begin
            for (int p = 0; p < fact(l); p++) begin
                for (int i = 0; i < 4; i++) avail[i] = i;
                k = p; cnt = l;
                for (int i = 0; i < l; i++) begin
                    f = fact(l - 1 - i); sel = k / f; k = k % f;
                    ord[i] = avail[sel];
                    for (int j = sel; j < cnt - 1; j++) avail[j] = avail[j + 1];
                    cnt--;
                end
                do_req(l, p, l, nw, ok, id);
                chk("R2 new", nw, 1); chk("R2 ok", ok, 1); chk("R2 lowest id", id, 0);
                for (int i = 0; i < l; i++) begin
                    do_pkt(0, ord[i], word(l, p, ord[i]), dv, did, dlen);
                    chk("R7 desc timing", dv, (i == l - 1) ? 1 : 0);
                    if (i == l - 1) begin
                        chk("R7 desc id", did, 0); chk("R7 desc len", dlen, l);
                    end
                    if (i == 0) begin
                        do_pkt(0, ord[0], word(l, p, ord[0]) ^ 16'hFFFF, dv, did, dlen);
                        chk("R6 duplicate no desc", dv, 0);
                        do_req(l, p, l, nw, ok, id);
                        chk("R3 hit new", nw, 0); chk("R3 hit ok", ok, 1); chk("R3 hit id", id, 0);
                    end
                end
                for (int i = 0; i < l; i++) begin
                    rd_id = 0; rd_idx = 2'(i); #1;
                    chk("R5 R6 stored word", int'(rd_data), word(l, p, i));
                end
                do_ack(0);
            end
        end

        // Illegal lengths.
        do_req(9, 9, 0, nw, ok, id); chk("R4 len 0 drop", ok, 0);
        do_req(9, 9, 5, nw, ok, id); chk("R4 len 5 drop", ok, 0);

        // Fill all four slots with one-packet messages, then overflow.
        for (int s = 0; s < 4; s++) begin
            do_req(100, s, 1, nw, ok, id);
            chk("R2 fill ok", ok, 1); chk("R2 fill id", id, s);
        end
        do_req(100, 7, 1, nw, ok, id); chk("R4 full drop", ok, 0);
        do_req(100, 2, 1, nw, ok, id);
        chk("R4 no state change hit", nw, 0); chk("R4 no state change id", id, 2);
        // Ack while filling is ignored: slot 2 still completes afterwards.
        do_ack(2);
        do_pkt(2, 0, 16'h1234, dv, did, dlen);
        chk("R8 ack on filling ignored", dv, 1); chk("R8 desc id", did, 2);
        // Release and allocation in the same cycle.
        ack_valid = 1; ack_id = 2; req_valid = 1; req_src = 100; req_smid = 8; req_len = 1;
        step();
        chk("R9 same-cycle alloc drops", int'(rsp_ok), 0);
        ack_valid = 0; req_valid = 0;
        do_req(100, 8, 1, nw, ok, id);
        chk("R9 next-cycle alloc ok", ok, 1); chk("R9 reuses slot", id, 2);
        // Acknowledge everything: complete slots 0,1,3,2 first.
        do_pkt(0, 0, 1, dv, did, dlen); do_pkt(1, 0, 1, dv, did, dlen);
        do_pkt(3, 0, 1, dv, did, dlen); do_pkt(2, 0, 1, dv, did, dlen);
        chk("R7 last one-packet desc", dv, 1);
        for (int s = 0; s < 4; s++) do_ack(s);

        // Packets beyond the length and to a free slot are ignored.
        do_pkt(1, 0, 16'hBEEF, dv, did, dlen); chk("R6 free slot no desc", dv, 0);
        do_req(50, 1, 2, nw, ok, id); chk("R8 released slot reused", id, 0);
        do_pkt(0, 3, 16'h0003, dv, did, dlen); chk("R6 out of range no desc", dv, 0);
        do_pkt(0, 1, 16'h0001, dv, did, dlen); chk("R6 one of two no desc", dv, 0);
        do_pkt(0, 0, 16'h0000, dv, did, dlen); chk("R7 two of two desc", dv, 1);
        do_req(50, 2, 1, nw, ok, id); chk("R2 next free id", id, 1);
        do_pkt(1, 0, 16'h00AA, dv, did, dlen);
        chk("R6 pre-alloc packet not counted", dv, 1);
        rd_id = 1; rd_idx = 0; #1;
        chk("R5 post-alloc word", int'(rd_data), 16'h00AA);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule